// File: doc/BRIEF.md
# Multi-Sequence ADC Sample Scheduler

This block shares one analog-to-digital converter among four sample sequencers. Each sequencer owns a short programmable list of conversion steps. A step names an input channel or the internal temperature sensor, picks single-ended or differential conversion, and carries two flags: one raises the sequencer's interrupt status when the step completes, and the other ends the list at that step. Each sequencer watches one trigger event, chosen from a software request or one of four hardware event lines.

A triggered sequencer becomes pending. Whenever the converter is free, an arbiter starts the pending sequencer with the best priority. That sequencer then walks its steps from step 0 until it reaches a step with the end flag or its last slot. Each step is one start/done exchange with the converter. The result goes into that sequencer's own FIFO along with the differential flag. A full FIFO drops the result and sets a sticky overflow flag. Software pops results through a shared read port that selects one FIFO.

Top module: `adcsched_top`

## Requirements
- R1: After reset, every FIFO is empty, every overflow and interrupt status bit is 0, `busy` is 0 and no conversion starts. Every sequencer is disabled, and every step holds zero (channel 0, no flags).
- R2: A started sequencer converts its steps in ascending order from step 0. While each conversion is outstanding, `conv_chan`, `conv_temp` and `conv_diff` show that step's settings.
- R3: A sequence ends after the conversion of the first step whose end flag is set. No further conversion is started for that run.
- R4: If no step has its end flag set, a sequence ends after its last slot. The capacities are 8, 4, 4 and 1 steps for sequencers 0, 1, 2 and 3.
- R5: Each result is written to the FIFO of the sequencer that produced it, with that step's differential flag. Results read back in conversion order. Each FIFO's depth equals its sequencer's capacity.
- R6: Among pending sequencers, the smallest 2-bit priority value runs first, and 0 is the best. On equal values, the lower sequencer index runs first.
- R7: The trigger source codes are 0 = software (`trig_sw[i]`), 1 = timer, 2 = comparator, 3 = PWM and 4 = GPIO. Events on lines other than the selected one do not start the sequencer.
- R8: A triggered sequencer whose enable bit is 0 does not become pending. Enabling it later does not start it.
- R9: Triggers that arrive while a sequencer is pending or running are held as a single pending request. Any number of them causes exactly one additional run.
- R10: When a step with its interrupt flag set completes, the sequencer's bit in `irq_raw` becomes 1 on the following cycle. Writing 1 to that bit of `irq_clr` clears it. A bit is not set by steps whose interrupt flag is 0.
- R11: A result that arrives while its FIFO is full is discarded, and the FIFO contents stay unchanged. The sequencer's `fifo_ovf` bit becomes 1 and remains 1.
- R12: `conv_start` is a single-cycle pulse. Only one conversion is outstanding at a time, and no new start is issued until `conv_done` has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_we | input | 1 | Write one step entry |
| step_seq | input | 2 | Sequencer of the step write |
| step_idx | input | 3 | Step slot of the write (ignored at or above capacity) |
| step_chan | input | 4 | Input channel of the step |
| step_temp | input | 1 | Step converts the temperature sensor |
| step_diff | input | 1 | Step uses differential mode |
| step_ie | input | 1 | Step raises interrupt status on completion |
| step_eos | input | 1 | Step ends the sequence |
| ctl_we | input | 1 | Write one sequencer control entry |
| ctl_seq | input | 2 | Sequencer of the control write |
| ctl_en | input | 1 | Sequencer enable |
| ctl_prio | input | 2 | Priority, 0 best |
| ctl_src | input | 3 | Trigger source code |
| trig_sw | input | 4 | Per-sequencer software trigger pulses |
| trig_timer | input | 1 | Timer event pulse |
| trig_comp | input | 1 | Comparator event pulse |
| trig_pwm | input | 1 | PWM event pulse |
| trig_gpio | input | 1 | GPIO event pulse |
| conv_start | output | 1 | Start one conversion |
| conv_chan | output | 4 | Channel for the current conversion |
| conv_temp | output | 1 | Current conversion reads the temperature sensor |
| conv_diff | output | 1 | Current conversion is differential |
| conv_done | input | 1 | Converter finished, data valid |
| conv_data | input | 10 | Conversion result |
| rd_seq | input | 2 | FIFO selected for reading |
| rd_pop | input | 1 | Remove the head entry of the selected FIFO |
| rd_data | output | 10 | Head result of the selected FIFO |
| rd_diff | output | 1 | Differential flag of that result |
| fifo_empty | output | 4 | Per-FIFO empty flags |
| fifo_ovf | output | 4 | Per-FIFO sticky overflow flags |
| irq_raw | output | 4 | Raw interrupt status per sequencer |
| irq_clr | input | 4 | Write-one-to-clear for `irq_raw` |
| busy | output | 1 | A conversion is outstanding |

## Verification
The bench uses the package defaults throughout: capacities 8, 4, 4 and 1, a 10-bit result and 2-bit priorities. With these values both the deep sequencer and the single-slot one can be tested. The single slot fills with one run, so the overflow path is reached with two triggers. The eight-slot FIFO can hold two back-to-back runs, so the latched retrigger can be seen without draining. The converter model in the bench varies its latency, and random step lists place the end flag at every position, including none.

// File: rtl/adcsched_pkg.sv
package adcsched_pkg;

    localparam int NSEQ      = 4;
    localparam int MAX_STEPS = 8;
    localparam int STEP_W    = $clog2(MAX_STEPS);
    localparam int SEQ_W     = $clog2(NSEQ);
    localparam int PRIO_W    = 2;
    localparam int CHAN_W    = 4;
    localparam int DATA_W    = 10;
    localparam int SRC_W     = 3;
    localparam int RES_W     = DATA_W + 1;

    typedef enum logic [SRC_W-1:0] {
        SRC_SW    = 3'd0,
        SRC_TIMER = 3'd1,
        SRC_COMP  = 3'd2,
        SRC_PWM   = 3'd3,
        SRC_GPIO  = 3'd4
    } trig_src_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              temp;
        logic              diff;
        logic              ie;
        logic              eos;
    } step_cfg_t;

    typedef struct packed {
        logic              en;
        logic [PRIO_W-1:0] prio;
        trig_src_e         src;
    } seq_ctl_t;

    typedef struct packed {
        logic              diff;
        logic [DATA_W-1:0] data;
    } result_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } fsm_e;

    // Step capacity (and FIFO depth) of each sequencer.
    function automatic int seq_capacity(input int idx);
        case (idx)
            0:       return 8;
            1:       return 4;
            2:       return 4;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/adcsched_trig_latch.sv
module adcsched_trig_latch
    import adcsched_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  trig_src_e src,
    input  logic      sw_evt,
    input  logic      tmr_evt,
    input  logic      cmp_evt,
    input  logic      pwm_evt,
    input  logic      gpio_evt,
    input  logic      grant,
    output logic      pend
);

    logic sel_evt;

    always_comb begin
        case (src)
            SRC_SW:    sel_evt = sw_evt;
            SRC_TIMER: sel_evt = tmr_evt;
            SRC_COMP:  sel_evt = cmp_evt;
            SRC_PWM:   sel_evt = pwm_evt;
            SRC_GPIO:  sel_evt = gpio_evt;
            default:   sel_evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else     pend <= (pend & ~grant) | (en & sel_evt);
    end

    assert_disabled_ignores_R8: assert property (@(posedge clk) disable iff (rst)
        (!en && !pend) |=> !pend);

    assert_pending_held_R9: assert property (@(posedge clk) disable iff (rst)
        (pend && !grant) |=> pend);

endmodule

// File: rtl/adcsched_arbiter.sv
module adcsched_arbiter #(
    parameter int N  = 4,
    parameter int PW = 2,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    pend,
    input  logic [N*PW-1:0] prio_flat,
    output logic            win_valid,
    output logic [IW-1:0]   win_idx
);

    logic [PW-1:0] best;

    // Strict less-than keeps the lower index on equal priority.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        best      = '1;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && (!win_valid || (prio_flat[i*PW +: PW] < best))) begin
                win_valid = 1'b1;
                win_idx   = IW'(i);
                best      = prio_flat[i*PW +: PW];
            end
        end
    end

endmodule

// File: rtl/adcsched_fifo.sv
module adcsched_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 11,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int SLOTS = 1 << PW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         ovf
);

    logic [W-1:0]  mem [SLOTS];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
            ovf  <= 1'b0;
            for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wptr] <= din;
                wptr      <= bump(wptr);
            end
            if (do_pop) rptr <= bump(rptr);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
            if (push && full) ovf <= 1'b1;
        end
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (cnt == $past(cnt)));

    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/adcsched_top.sv
module adcsched_top
    import adcsched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_we,
    input  logic [SEQ_W-1:0]  step_seq,
    input  logic [STEP_W-1:0] step_idx,
    input  logic [CHAN_W-1:0] step_chan,
    input  logic              step_temp,
    input  logic              step_diff,
    input  logic              step_ie,
    input  logic              step_eos,
    input  logic              ctl_we,
    input  logic [SEQ_W-1:0]  ctl_seq,
    input  logic              ctl_en,
    input  logic [PRIO_W-1:0] ctl_prio,
    input  logic [SRC_W-1:0]  ctl_src,
    input  logic [NSEQ-1:0]   trig_sw,
    input  logic              trig_timer,
    input  logic              trig_comp,
    input  logic              trig_pwm,
    input  logic              trig_gpio,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              conv_temp,
    output logic              conv_diff,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic [SEQ_W-1:0]  rd_seq,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_diff,
    output logic [NSEQ-1:0]   fifo_empty,
    output logic [NSEQ-1:0]   fifo_ovf,
    output logic [NSEQ-1:0]   irq_raw,
    input  logic [NSEQ-1:0]   irq_clr,
    output logic              busy
);

    step_cfg_t steps [NSEQ][MAX_STEPS];
    seq_ctl_t  ctl_q [NSEQ];

    fsm_e              state;
    logic [SEQ_W-1:0]  cur_seq;
    logic [STEP_W-1:0] cur_step;
    logic [STEP_W-1:0] cur_last_idx;
    logic              start_q;
    step_cfg_t         cur_cfg;
    logic              last_step;

    logic [NSEQ-1:0]        pend, grant, push, pop;
    logic [NSEQ*PRIO_W-1:0] prio_flat;
    logic                   win_valid;
    logic [SEQ_W-1:0]       win_idx;
    logic [RES_W-1:0]       head [NSEQ];
    logic [NSEQ-1:0]        full_unused;
    result_t                rd_res, wr_res;

    // ---------------- configuration storage ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSEQ; s++) begin
                ctl_q[s] <= '{en: 1'b0, prio: '0, src: SRC_SW};
                for (int k = 0; k < MAX_STEPS; k++) steps[s][k] <= '0;
            end
        end else begin
            if (step_we && (int'(step_idx) < seq_capacity(int'(step_seq))))
                steps[step_seq][step_idx] <= '{chan: step_chan, temp: step_temp,
                                               diff: step_diff, ie: step_ie,
                                               eos: step_eos};
            if (ctl_we)
                ctl_q[ctl_seq] <= '{en: ctl_en, prio: ctl_prio,
                                    src: trig_src_e'(ctl_src)};
        end
    end

    // ---------------- triggers and arbitration ----------------
    for (genvar g = 0; g < NSEQ; g++) begin : g_seq
        adcsched_trig_latch u_trig (
            .clk      (clk),
            .rst      (rst),
            .en       (ctl_q[g].en),
            .src      (ctl_q[g].src),
            .sw_evt   (trig_sw[g]),
            .tmr_evt  (trig_timer),
            .cmp_evt  (trig_comp),
            .pwm_evt  (trig_pwm),
            .gpio_evt (trig_gpio),
            .grant    (grant[g]),
            .pend     (pend[g])
        );

        assign prio_flat[g*PRIO_W +: PRIO_W] = ctl_q[g].prio;
        assign grant[g] = (state == ST_IDLE) && win_valid && (win_idx == SEQ_W'(g));
        assign push[g]  = (state == ST_WAIT) && conv_done && (cur_seq == SEQ_W'(g));
        assign pop[g]   = rd_pop && (rd_seq == SEQ_W'(g));

        adcsched_fifo #(
            .DEPTH (seq_capacity(g)),
            .W     (RES_W)
        ) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (push[g]),
            .din   (wr_res),
            .pop   (pop[g]),
            .dout  (head[g]),
            .empty (fifo_empty[g]),
            .full  (full_unused[g]),
            .ovf   (fifo_ovf[g])
        );

        always_ff @(posedge clk) begin
            if (rst) irq_raw[g] <= 1'b0;
            else     irq_raw[g] <= (irq_raw[g] & ~irq_clr[g]) | (push[g] & cur_cfg.ie);
        end

        assert_irq_after_done_R10: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_raw[g]) |-> $past(conv_done));

        assert_priority_order_R6: assert property (@(posedge clk) disable iff (rst)
            (win_valid && pend[g]) |->
                ((prio_flat[g*PRIO_W +: PRIO_W] > prio_flat[win_idx*PRIO_W +: PRIO_W]) ||
                 ((prio_flat[g*PRIO_W +: PRIO_W] == prio_flat[win_idx*PRIO_W +: PRIO_W]) &&
                  (SEQ_W'(g) >= win_idx))));
    end

    adcsched_arbiter #(
        .N  (NSEQ),
        .PW (PRIO_W)
    ) u_arb (
        .pend      (pend),
        .prio_flat (prio_flat),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    // ---------------- step sequencing ----------------
    always_comb begin
        cur_cfg      = steps[cur_seq][cur_step];
        cur_last_idx = STEP_W'(seq_capacity(int'(cur_seq)) - 1);
        last_step    = cur_cfg.eos || (cur_step == cur_last_idx);
        wr_res       = '{diff: cur_cfg.diff, data: conv_data};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_seq  <= '0;
            cur_step <= '0;
            start_q  <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state)
                ST_IDLE: if (win_valid) begin
                    cur_seq  <= win_idx;
                    cur_step <= '0;
                    start_q  <= 1'b1;
                    state    <= ST_WAIT;
                end
                ST_WAIT: if (conv_done) begin
                    if (last_step) begin
                        state <= ST_IDLE;
                    end else begin
                        cur_step <= cur_step + 1'b1;
                        start_q  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign conv_start = start_q;
    assign conv_chan  = cur_cfg.chan;
    assign conv_temp  = cur_cfg.temp;
    assign conv_diff  = cur_cfg.diff;
    assign busy       = (state == ST_WAIT);

    always_comb begin
        rd_res  = result_t'(head[rd_seq]);
        rd_data = rd_res.data;
        rd_diff = rd_res.diff;
    end

    // ---------------- assertions ----------------
    assert_start_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    assert_one_outstanding_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && !conv_done) |=> !conv_start);

    assert_stop_at_end_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && conv_done && cur_cfg.eos) |=> (!conv_start && !busy));

    assert_cap_limit_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cur_step <= cur_last_idx));

endmodule

// File: tb/tb_adcsched_top.sv
`timescale 1ns/1ps
module tb_adcsched_top;
    import adcsched_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic step_we = 0, step_temp = 0, step_diff = 0, step_ie = 0, step_eos = 0;
    logic [1:0] step_seq = 0;
    logic [2:0] step_idx = 0;
    logic [3:0] step_chan = 0;
    logic ctl_we = 0, ctl_en = 0;
    logic [1:0] ctl_seq = 0, ctl_prio = 0;
    logic [2:0] ctl_src = 0;
    logic [3:0] trig_sw = 0;
    logic trig_timer = 0, trig_comp = 0, trig_pwm = 0, trig_gpio = 0;
    logic conv_start, conv_temp, conv_diff;
    logic [3:0] conv_chan;
    logic conv_done = 0;
    logic [9:0] conv_data = 0;
    logic [1:0] rd_seq = 0;
    logic rd_pop = 0;
    logic [9:0] rd_data;
    logic rd_diff;
    logic [3:0] fifo_empty, fifo_ovf, irq_raw;
    logic [3:0] irq_clr = 0;
    logic busy;

    adcsched_top dut (
        .clk(clk), .rst(rst),
        .step_we(step_we), .step_seq(step_seq), .step_idx(step_idx),
        .step_chan(step_chan), .step_temp(step_temp), .step_diff(step_diff),
        .step_ie(step_ie), .step_eos(step_eos),
        .ctl_we(ctl_we), .ctl_seq(ctl_seq), .ctl_en(ctl_en),
        .ctl_prio(ctl_prio), .ctl_src(ctl_src),
        .trig_sw(trig_sw), .trig_timer(trig_timer), .trig_comp(trig_comp),
        .trig_pwm(trig_pwm), .trig_gpio(trig_gpio),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_temp(conv_temp),
        .conv_diff(conv_diff), .conv_done(conv_done), .conv_data(conv_data),
        .rd_seq(rd_seq), .rd_pop(rd_pop), .rd_data(rd_data), .rd_diff(rd_diff),
        .fifo_empty(fifo_empty), .fifo_ovf(fifo_ovf), .irq_raw(irq_raw),
        .irq_clr(irq_clr), .busy(busy)
    );

    int n_checks = 0, n_fail = 0;
    bit reported = 0;

    // Mirror of the programmed step lists (stimulus bookkeeping).
    int b_chan [4][8];
    bit b_temp [4][8], b_diff [4][8], b_eos [4][8];

    // Converter model log.
    int log_n = 0, lat = 2;
    int log_chan [512];
    bit log_temp [512], log_diff [512];
    int log_data [512];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    function automatic int cap_of(input int s);
        return (s == 0) ? 8 : (s == 3) ? 1 : 4;
    endfunction

    function automatic int exp_len(input int s);
        for (int i = 0; i < cap_of(s); i++) if (b_eos[s][i]) return i + 1;
        return cap_of(s);
    endfunction

    // Converter: one conversion at a time, variable latency.
    initial begin
        forever begin
            @(negedge clk);
            conv_done = 0;
            if (conv_start) begin
                log_chan[log_n] = int'(conv_chan);
                log_temp[log_n] = conv_temp;
                log_diff[log_n] = conv_diff;
                log_data[log_n] = ((log_n % 64) << 4) | int'(conv_chan);
                repeat (lat) @(negedge clk);
                conv_data = 10'(log_data[log_n]);
                log_n++;
                conv_done = 1;
            end
        end
    end

    task automatic prog_step(input int s, input int i, input int ch, input bit tp,
                             input bit df, input bit ie, input bit eos);
        @(negedge clk);
        step_we = 1; step_seq = 2'(s); step_idx = 3'(i); step_chan = 4'(ch);
        step_temp = tp; step_diff = df; step_ie = ie; step_eos = eos;
        @(negedge clk);
        step_we = 0;
        b_chan[s][i] = ch; b_temp[s][i] = tp; b_diff[s][i] = df; b_eos[s][i] = eos;
    endtask

    task automatic prog_ctl(input int s, input bit en, input int prio, input int src);
        @(negedge clk);
        ctl_we = 1; ctl_seq = 2'(s); ctl_en = en; ctl_prio = 2'(prio); ctl_src = 3'(src);
        @(negedge clk);
        ctl_we = 0;
    endtask

    // which: 0..3 software bit, 4 timer, 5 comp, 6 pwm, 7 gpio
    task automatic pulse(input int which);
        @(negedge clk);
        if (which < 4) trig_sw[which] = 1;
        else if (which == 4) trig_timer = 1;
        else if (which == 5) trig_comp = 1;
        else if (which == 6) trig_pwm = 1;
        else trig_gpio = 1;
        @(negedge clk);
        trig_sw = 0; trig_timer = 0; trig_comp = 0; trig_pwm = 0; trig_gpio = 0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 6) begin
            @(negedge clk);
            if (!busy && !conv_start && !conv_done) q++; else q = 0;
        end
    endtask

    // Checks one run of sequencer s starting at log index base.
    task automatic check_run(input int s, input int base, input string req);
        for (int i = 0; i < exp_len(s); i++) begin
            check(log_chan[base+i] == b_chan[s][i], req, log_chan[base+i], b_chan[s][i]);
            check(log_temp[base+i] == b_temp[s][i], req, log_temp[base+i], b_temp[s][i]);
            check(log_diff[base+i] == b_diff[s][i], req, log_diff[base+i], b_diff[s][i]);
        end
    endtask

    // Pops n entries of FIFO s and compares them with log entries from base.
    task automatic drain(input int s, input int base, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rd_seq = 2'(s);
            #1;
            check(fifo_empty[s] == 0, "R5 fifo nonempty", fifo_empty[s], 0);
            check(int'(rd_data) == log_data[base+k], "R5 data", rd_data, log_data[base+k]);
            check(rd_diff == log_diff[base+k], "R5 diff flag", rd_diff, log_diff[base+k]);
            rd_pop = 1;
            @(negedge clk);
            rd_pop = 0;
        end
        #1;
        check(fifo_empty[s] == 1, "R5 fifo empty after drain", fifo_empty[s], 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        report();
    end

    initial begin
        int base, seed;
        seed = 17;
        void'($urandom(seed));
        for (int s = 0; s < 4; s++)
            for (int i = 0; i < 8; i++) begin
                b_chan[s][i] = 0; b_temp[s][i] = 0; b_diff[s][i] = 0; b_eos[s][i] = 0;
            end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        check(fifo_empty == 4'hF, "R1 empty", fifo_empty, 15);
        check(fifo_ovf == 0, "R1 ovf", fifo_ovf, 0);
        check(irq_raw == 0, "R1 irq", irq_raw, 0);
        check(busy == 0 && conv_start == 0, "R1 idle", busy, 0);
        pulse(0);
        wait_quiet();
        check(log_n == 0, "R1 disabled after reset", log_n, 0);

        // Program step lists
        for (int i = 0; i < 8; i++) prog_step(0, i, i, 0, i == 1, 0, i == 2);
        for (int i = 0; i < 4; i++) prog_step(1, i, 8 + i, 0, i == 1, i == 3, 0);
        for (int i = 0; i < 4; i++) prog_step(2, i, 12 + i, 0, 0, 0, i == 2);
        prog_step(3, 0, 0, 1, 0, 1, 0);

        // R2/R3: seq0 ends at step 2
        prog_ctl(0, 1, 0, 0);
        base = log_n;
        pulse(0);
        wait_quiet();
        check(log_n - base == 3, "R3 run length", log_n - base, 3);
        check_run(0, base, "R2 step order");
        check(irq_raw == 0, "R10 no ie no irq", irq_raw, 0);
        drain(0, base, 3);

        // R4: seq1 runs to capacity, R10 irq on last step
        prog_ctl(1, 1, 0, 0);
        base = log_n;
        pulse(1);
        wait_quiet();
        check(log_n - base == 4, "R4 capacity stop", log_n - base, 4);
        check_run(1, base, "R4 step order");
        check(irq_raw == 4'b0010, "R10 irq set", irq_raw, 2);
        drain(1, base, 4);
        @(negedge clk); irq_clr = 4'b0010;
        @(negedge clk); irq_clr = 0;
        check(irq_raw == 0, "R10 irq cleared", irq_raw, 0);

        // R6/R7: all on timer, prio 2,1,1,3 -> order 1,2,0,3
        lat = 3;
        prog_ctl(0, 1, 2, 1);
        prog_ctl(1, 1, 1, 1);
        prog_ctl(2, 1, 1, 1);
        prog_ctl(3, 1, 3, 1);
        base = log_n;
        pulse(4);
        wait_quiet();
        check(log_n - base == 11, "R6 total conversions", log_n - base, 11);
        check_run(1, base, "R6 first seq1");
        check_run(2, base + 4, "R6 second seq2");
        check_run(0, base + 7, "R6 third seq0");
        check_run(3, base + 10, "R6 last seq3");
        drain(1, base, 4);
        drain(2, base + 4, 3);
        drain(0, base + 7, 3);
        drain(3, base + 10, 1);
        @(negedge clk); irq_clr = 4'hF;
        @(negedge clk); irq_clr = 0;

        // R7: seq2 on PWM only
        prog_ctl(0, 0, 0, 0);
        prog_ctl(1, 0, 0, 0);
        prog_ctl(3, 0, 0, 0);
        prog_ctl(2, 1, 0, 3);
        base = log_n;
        pulse(4); pulse(5); pulse(7); pulse(2);
        wait_quiet();
        check(log_n == base, "R7 other sources ignored", log_n - base, 0);
        pulse(6);
        wait_quiet();
        check(log_n - base == 3, "R7 pwm starts", log_n - base, 3);
        drain(2, base, 3);

        // R8: disabled seq3 ignores trigger
        prog_ctl(2, 0, 0, 0);
        prog_ctl(3, 0, 0, 0);
        base = log_n;
        pulse(3);
        prog_ctl(3, 1, 0, 0);
        wait_quiet();
        check(log_n == base, "R8 disabled ignored", log_n - base, 0);
        check(fifo_empty[3] == 1, "R8 fifo untouched", fifo_empty[3], 1);

        // R9: retriggers while running -> one extra run
        prog_ctl(3, 0, 0, 0);
        prog_ctl(0, 1, 0, 0);
        lat = 8;
        base = log_n;
        pulse(0);
        repeat (3) @(negedge clk);
        pulse(0); pulse(0);
        repeat (4) @(negedge clk);
        pulse(0);
        wait_quiet();
        check(log_n - base == 6, "R9 latched once", log_n - base, 6);
        check_run(0, base, "R9 first run");
        check_run(0, base + 3, "R9 second run");
        drain(0, base, 6);

        // R11: seq3 overflow
        lat = 1;
        prog_ctl(0, 0, 0, 0);
        prog_ctl(3, 1, 0, 0);
        base = log_n;
        pulse(3);
        wait_quiet();
        check(fifo_ovf[3] == 0, "R11 no ovf yet", fifo_ovf[3], 0);
        pulse(3);
        wait_quiet();
        check(log_n - base == 2, "R11 two conversions", log_n - base, 2);
        check(fifo_ovf == 4'b1000, "R11 ovf set", fifo_ovf, 8);
        check(irq_raw[3] == 1, "R10 seq3 irq", irq_raw[3], 1);
        drain(3, base, 1);
        check(fifo_ovf[3] == 1, "R11 ovf sticky", fifo_ovf[3], 1);
        prog_ctl(3, 0, 0, 0);

        // Random step lists on seq0..2 (R2, R3, R4, R5)
        for (int it = 0; it < 40; it++) begin
            int s;
            s = int'($urandom_range(0, 2));
            lat = int'($urandom_range(1, 4));
            for (int i = 0; i < cap_of(s); i++)
                prog_step(s, i, int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
                          1'($urandom_range(0, 1)), 0, ($urandom_range(0, 3) == 0));
            prog_ctl(s, 1, int'($urandom_range(0, 3)), 0);
            base = log_n;
            pulse(s);
            wait_quiet();
            check(log_n - base == exp_len(s), "R3 random length", log_n - base, exp_len(s));
            check_run(s, base, "R2 random steps");
            drain(s, base, exp_len(s));
            prog_ctl(s, 0, 0, 0);
        end

        report();
    end

endmodule